// File: doc/BRIEF.md
# Multi-Channel DMA Control and Status Register Bank

This block is the register front end of a DMA controller with up to 64 channels. For each channel it keeps four bits: request enable, error-interrupt enable, interrupt pending and error pending. Each group of bits forms a 64-bit vector that software sees as two 32-bit words. The high word holds channels 63..32 and the low word holds channels 31..0. The engine reports major-loop completion and errors on side-band ports. The bank records these events as pending bits, and it latches the first error together with its cause and channel. It combines the pending state into one interrupt line.

Software changes a single channel's bit by writing that channel's number to one of eight command bytes. A read-modify-write of the 64-bit masks is never needed. A command byte with bit 6 set acts on every channel. The pending words are write-one-to-clear. The same command bytes also produce one-cycle start pulses and done-clear pulses toward the channel engines. A reduced build with `NUM_CH` of 32 or less keeps only the low words. In that build the high words read as zero and ignore writes.

Top module: `chreg_bank`

## Requirements
- R1: After reset every vector, the control word and the error status word read 0, irq_o is low and all per-channel outputs are 0.
- R2: Request enable (high word at 0x08, low word at 0x0C) and error-interrupt enable (high word at 0x10, low word at 0x14) are read/write. A write loads only the byte lanes whose be_i bit is set. Bit j of a high word is channel 32+j and bit j of a low word is channel j.
- R3: Command bytes sit in the word at 0x18 (lane 0 sets request enable, lane 1 clears request enable, lane 2 sets error-interrupt enable, lane 3 clears error-interrupt enable) and in the word at 0x1C (lane 0 clears interrupt, lane 1 clears error, lane 2 starts, lane 3 clears done). Lane n is wdata_i[8n+7:8n] with be_i[n]. Bits 5:0 give the channel, bit 7 is ignored, and only the named channel changes.
- R4: A command byte with bit 6 set acts on all channels at once.
- R5: If one write both sets and clears the same enable bit, the clear wins.
- R6: A done_i bit sets that channel's interrupt pending bit. Software clears it with the clear-interrupt command or by writing 1s to 0x20 (high) or 0x24 (low). A done_i bit in the same cycle as a clear leaves the bit set.
- R7: err_ev_i sets the error pending bit of channel err_ch_i. Software clears it with the clear-error command or by writing 1s to 0x28 (high) or 0x2C (low). A new error in the same cycle as a clear leaves the bit set.
- R8: The error status word at 0x04 is laid out as follows: bit 31 valid, bit 15 = err_cause_i[9], bit 14 = err_cause_i[8], bits 13:8 the channel, bits 7:0 = err_cause_i[7:0]. It is latched on an error only while not valid, so later errors leave it unchanged.
- R9: The error status returns to 0 when software clears the error pending bit of the latched channel. If a new error arrives in that same cycle, the new error is latched instead.
- R10: irq_o is high whenever any interrupt pending bit is set, or any error pending bit is set whose error-interrupt enable bit is also set.
- R11: The start command and the clear-done command each raise start_o and done_clr_o respectively, for the selected channels, for exactly the one cycle that follows the write.
- R12: The control word at 0x00 is read/write under be_i. The word at 0x30 reads hw_req_i[63:32] and the word at 0x34 reads hw_req_i[31:0]. The command words and unused addresses read 0. An access with addr_i[1:0] not 00 is ignored and reads 0.
- R13: req_en_o always equals the request-enable vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Byte address for writes and combinational reads |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte-lane enables |
| rdata_o | output | 32 | Read data for addr_i |
| done_i | input | NUM_CH | Major-loop done event per channel |
| err_ev_i | input | 1 | Engine error event |
| err_ch_i | input | 6 | Channel of the error event |
| err_cause_i | input | 10 | Error cause flags |
| hw_req_i | input | NUM_CH | Live hardware request lines |
| req_en_o | output | NUM_CH | Request enable per channel |
| start_o | output | NUM_CH | One-cycle start pulse per channel |
| done_clr_o | output | NUM_CH | One-cycle done-clear pulse per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench targets the collisions between hardware and software. A done or error event that lands in the same cycle as its clear must survive; a design that let the clear win would lose a completion. A second error must not overwrite the latched status, and clearing a different channel's error must not release it; getting either wrong would report the wrong failing channel. The bench also covers the remaining corner cases. A set and a clear of the same enable in one write must leave the bit clear. A broadcast byte with bit 6 set must reach all 64 channels, and bit 7 must not alter the channel index. An error whose interrupt enable is off must stay silent on irq_o.

// File: rtl/chreg_pkg.sv
`timescale 1ns/1ps
package chreg_pkg;
  localparam int unsigned MAX_CH  = 64;
  localparam int unsigned IDX_W   = 6;
  localparam int unsigned CAUSE_W = 10;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned N_CMD   = 8;

  typedef enum logic [3:0] {
    W_CTRL    = 4'd0,
    W_ESTAT   = 4'd1,
    W_REQ_HI  = 4'd2,
    W_REQ_LO  = 4'd3,
    W_EEI_HI  = 4'd4,
    W_EEI_LO  = 4'd5,
    W_CMD_A   = 4'd6,
    W_CMD_B   = 4'd7,
    W_INT_HI  = 4'd8,
    W_INT_LO  = 4'd9,
    W_ERR_HI  = 4'd10,
    W_ERR_LO  = 4'd11,
    W_HWRQ_HI = 4'd12,
    W_HWRQ_LO = 4'd13
  } word_e;

  // command index = {word select, lane}
  typedef enum logic [2:0] {
    C_SET_REQ   = 3'd0,
    C_CLR_REQ   = 3'd1,
    C_SET_EEI   = 3'd2,
    C_CLR_EEI   = 3'd3,
    C_CLR_INT   = 3'd4,
    C_CLR_ERR   = 3'd5,
    C_SET_START = 3'd6,
    C_CLR_DONE  = 3'd7
  } cmd_e;

  typedef struct packed {
    logic             vld;
    logic             grp_pri;
    logic             ch_pri;
    logic [IDX_W-1:0] ch;
    logic [7:0]       src;
  } estat_t;
endpackage

// File: rtl/chreg_chan_sel.sv
`timescale 1ns/1ps
module chreg_chan_sel #(
  parameter int unsigned N = 64
) (
  input  logic         en_i,
  input  logic [6:0]   code_i,
  output logic [N-1:0] mask_o
);
  always_comb begin
    mask_o = '0;
    if (en_i) begin
      if (code_i[6]) begin
        mask_o = '1;
      end else begin
        for (int unsigned c = 0; c < N; c++) begin
          if ({26'd0, code_i[5:0]} == c) mask_o[c] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/chreg_bitvec.sv
`timescale 1ns/1ps
module chreg_bitvec #(
  parameter int unsigned N        = 64,
  parameter bit          SET_WINS = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ld_mask_i,
  input  logic [N-1:0] ld_val_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] base, nxt;

  assign base = (q_o & ~ld_mask_i) | (ld_val_i & ld_mask_i);

  generate
    if (SET_WINS) begin : g_set_wins
      // hardware events must never be lost to a software clear
      assign nxt = (base & ~clr_i) | set_i;
      p_event_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));
    end else begin : g_clr_wins
      assign nxt = (base | set_i) & ~clr_i;
      p_clear_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|clr_i) |=> ((q_o & $past(clr_i)) == '0));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/chreg_err_latch.sv
`timescale 1ns/1ps
module chreg_err_latch
  import chreg_pkg::*;
#(
  parameter int unsigned N = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ev_i,
  input  logic [IDX_W-1:0]   ev_ch_i,
  input  logic [CAUSE_W-1:0] ev_cause_i,
  input  logic [N-1:0]       sw_clr_i,
  output estat_t             stat_o
);
  logic [MAX_CH-1:0] clr64;
  logic              hit;

  assign clr64 = MAX_CH'(sw_clr_i);
  assign hit   = stat_o.vld & clr64[stat_o.ch];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_o <= '0;
    end else if (ev_i && (!stat_o.vld || hit)) begin
      stat_o <= '{vld: 1'b1, grp_pri: ev_cause_i[9], ch_pri: ev_cause_i[8],
                  ch: ev_ch_i, src: ev_cause_i[7:0]};
    end else if (hit) begin
      stat_o <= '0;
    end
  end

  p_first_err_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o.vld && !clr64[stat_o.ch]) |=> $stable(stat_o));
  p_release_on_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_o.vld && clr64[stat_o.ch] && !ev_i) |=> !stat_o.vld);
  p_latch_new_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_o.vld && ev_i) |=> (stat_o.vld && stat_o.ch == $past(ev_ch_i)));
endmodule

// File: rtl/chreg_bank.sv
`timescale 1ns/1ps
module chreg_bank
  import chreg_pkg::*;
#(
  parameter int unsigned NUM_CH = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  input  logic [3:0]          be_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_CH-1:0]   done_i,
  input  logic                err_ev_i,
  input  logic [IDX_W-1:0]    err_ch_i,
  input  logic [CAUSE_W-1:0]  err_cause_i,
  input  logic [NUM_CH-1:0]   hw_req_i,
  output logic [NUM_CH-1:0]   req_en_o,
  output logic [NUM_CH-1:0]   start_o,
  output logic [NUM_CH-1:0]   done_clr_o,
  output logic                irq_o
);
  localparam int unsigned LO_W = (NUM_CH < 32) ? NUM_CH : 32;

  word_e       widx;
  logic        aligned, wr_ok;
  logic [31:0] lane_m;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign widx    = word_e'(addr_i[ADDR_W-1:2]);
  assign wr_ok   = wr_en_i & aligned;
  assign lane_m  = {{8{be_i[3]}}, {8{be_i[2]}}, {8{be_i[1]}}, {8{be_i[0]}}};

  // command bytes
  logic [NUM_CH-1:0] cmd_mask [N_CMD];

  generate
    for (genvar k = 0; k < N_CMD; k++) begin : g_cmd
      localparam logic [3:0] CW = (k < 4) ? W_CMD_A : W_CMD_B;
      localparam int unsigned LN = k % 4;
      logic en;
      assign en = wr_ok && (addr_i[ADDR_W-1:2] == CW) && be_i[LN];
      chreg_chan_sel #(.N(NUM_CH)) u_sel (
        .en_i  (en),
        .code_i(wdata_i[8*LN +: 7]),
        .mask_o(cmd_mask[k])
      );
    end
  endgenerate

  // word writes
  logic [MAX_CH-1:0] req_ld64, eei_ld64, int_w1c64, err_w1c64, err_set64;
  logic [MAX_CH-1:0] wd64;
  logic [31:0]       ctrl_q;

  assign wd64 = {wdata_i, wdata_i};

  always_comb begin
    req_ld64  = '0;
    eei_ld64  = '0;
    int_w1c64 = '0;
    err_w1c64 = '0;
    if (wr_ok) begin
      case (widx)
        W_REQ_HI: req_ld64[63:32]  = lane_m;
        W_REQ_LO: req_ld64[31:0]   = lane_m;
        W_EEI_HI: eei_ld64[63:32]  = lane_m;
        W_EEI_LO: eei_ld64[31:0]   = lane_m;
        W_INT_HI: int_w1c64[63:32] = lane_m & wdata_i;
        W_INT_LO: int_w1c64[31:0]  = lane_m & wdata_i;
        W_ERR_HI: err_w1c64[63:32] = lane_m & wdata_i;
        W_ERR_LO: err_w1c64[31:0]  = lane_m & wdata_i;
        default: ;
      endcase
    end
  end

  assign err_set64 = err_ev_i ? (64'd1 << err_ch_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ok && widx == W_CTRL) begin
      ctrl_q <= (ctrl_q & ~lane_m) | (wdata_i & lane_m);
    end
  end

  // per-channel state
  logic [NUM_CH-1:0] req_q, eei_q, int_q, err_q, err_clr;

  assign err_clr = err_w1c64[NUM_CH-1:0] | cmd_mask[C_CLR_ERR];

  chreg_bitvec #(.N(NUM_CH), .SET_WINS(1'b0)) u_req (
    .clk_i, .rst_ni,
    .ld_mask_i(req_ld64[NUM_CH-1:0]), .ld_val_i(wd64[NUM_CH-1:0]),
    .set_i(cmd_mask[C_SET_REQ]), .clr_i(cmd_mask[C_CLR_REQ]), .q_o(req_q)
  );

  chreg_bitvec #(.N(NUM_CH), .SET_WINS(1'b0)) u_eei (
    .clk_i, .rst_ni,
    .ld_mask_i(eei_ld64[NUM_CH-1:0]), .ld_val_i(wd64[NUM_CH-1:0]),
    .set_i(cmd_mask[C_SET_EEI]), .clr_i(cmd_mask[C_CLR_EEI]), .q_o(eei_q)
  );

  chreg_bitvec #(.N(NUM_CH), .SET_WINS(1'b1)) u_int (
    .clk_i, .rst_ni,
    .ld_mask_i('0), .ld_val_i('0),
    .set_i(done_i), .clr_i(int_w1c64[NUM_CH-1:0] | cmd_mask[C_CLR_INT]), .q_o(int_q)
  );

  chreg_bitvec #(.N(NUM_CH), .SET_WINS(1'b1)) u_err (
    .clk_i, .rst_ni,
    .ld_mask_i('0), .ld_val_i('0),
    .set_i(err_set64[NUM_CH-1:0]), .clr_i(err_clr), .q_o(err_q)
  );

  estat_t estat;

  chreg_err_latch #(.N(NUM_CH)) u_estat (
    .clk_i, .rst_ni,
    .ev_i(err_ev_i), .ev_ch_i(err_ch_i), .ev_cause_i(err_cause_i),
    .sw_clr_i(err_clr), .stat_o(estat)
  );

  // engine pulses
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_o    <= '0;
      done_clr_o <= '0;
    end else begin
      start_o    <= cmd_mask[C_SET_START];
      done_clr_o <= cmd_mask[C_CLR_DONE];
    end
  end

  assign req_en_o = req_q;
  assign irq_o    = (|int_q) | (|(err_q & eei_q));

  // read path
  logic [MAX_CH-1:0] req64, eei64, int64, err64, hw64;
  assign req64 = MAX_CH'(req_q);
  assign eei64 = MAX_CH'(eei_q);
  assign int64 = MAX_CH'(int_q);
  assign err64 = MAX_CH'(err_q);
  assign hw64  = MAX_CH'(hw_req_i);

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      case (widx)
        W_CTRL:    rdata_o = ctrl_q;
        W_ESTAT:   rdata_o = {estat.vld, 15'd0, estat.grp_pri, estat.ch_pri, estat.ch, estat.src};
        W_REQ_HI:  rdata_o = req64[63:32];
        W_REQ_LO:  rdata_o = req64[31:0];
        W_EEI_HI:  rdata_o = eei64[63:32];
        W_EEI_LO:  rdata_o = eei64[31:0];
        W_INT_HI:  rdata_o = int64[63:32];
        W_INT_LO:  rdata_o = int64[31:0];
        W_ERR_HI:  rdata_o = err64[63:32];
        W_ERR_LO:  rdata_o = err64[31:0];
        W_HWRQ_HI: rdata_o = hw64[63:32];
        W_HWRQ_LO: rdata_o = hw64[31:0];
        default:   rdata_o = '0;
      endcase
    end
  end

  p_irq_after_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_i) |=> irq_o);
  p_pulse_needs_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|start_o || |done_clr_o) |-> $past(wr_en_i));
  p_reqen_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 6'h0C && be_i == 4'hF) |=> (req_en_o[LO_W-1:0] == $past(wdata_i[LO_W-1:0])));
  p_pulse_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|start_o) && !$past(wr_en_i, 2)) |=> (start_o == '0 || $past(wr_en_i)));
endmodule

// File: tb/chreg_bank_test.sv
`timescale 1ns/1ps
module chreg_bank_test;
  localparam int unsigned NCH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  be = '0;
  logic [31:0] rdata;
  logic [63:0] done = '0;
  logic        err_ev = 1'b0;
  logic [5:0]  err_ch = '0;
  logic [9:0]  err_cause = '0;
  logic [63:0] hw_req = '0;
  logic [63:0] req_en, start, done_clr;
  logic        irq;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  // model state
  logic [31:0] m_ctrl, m_stat;
  logic [63:0] m_req, m_eei, m_int, m_err, e_start, e_dclr;

  always #2.5 clk = ~clk;

  chreg_bank #(.NUM_CH(NCH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .be_i(be), .rdata_o(rdata), .done_i(done), .err_ev_i(err_ev), .err_ch_i(err_ch),
    .err_cause_i(err_cause), .hw_req_i(hw_req), .req_en_o(req_en), .start_o(start),
    .done_clr_o(done_clr), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] sel64(input logic [7:0] c);
    if (c[6]) return '1;
    return 64'd1 << c[5:0];
  endfunction

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    if (a[1:0] != 2'b00) return '0;
    case (a[5:2])
      4'd0:  return m_ctrl;
      4'd1:  return m_stat;
      4'd2:  return m_req[63:32];
      4'd3:  return m_req[31:0];
      4'd4:  return m_eei[63:32];
      4'd5:  return m_eei[31:0];
      4'd8:  return m_int[63:32];
      4'd9:  return m_int[31:0];
      4'd10: return m_err[63:32];
      4'd11: return m_err[31:0];
      4'd12: return hw_req[63:32];
      4'd13: return hw_req[31:0];
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] w);
    case (w)
      4'd1: return "R8 estat";
      4'd2, 4'd3, 4'd4, 4'd5: return "R2 enable word";
      4'd8, 4'd9: return "R6 int word";
      4'd10, 4'd11: return "R7 err word";
      default: return "R12 misc word";
    endcase
  endfunction

  task automatic read_all();
    for (int w = 0; w < 16; w++) begin
      addr = 6'(w << 2);
      #0.1;
      chk(tag_of(4'(w)), {32'd0, rdata}, {32'd0, exp_rd(addr)});
    end
  endtask

  // one clock with stimulus, model update, and full check
  task automatic step(input logic wr, input logic [5:0] a, input logic [31:0] d,
                      input logic [3:0] b, input logic [63:0] dn, input logic ev,
                      input logic [5:0] ch, input logic [9:0] cs);
    logic [31:0] lm;
    logic [63:0] cm [8];
    logic [63:0] ldr, lde, wi, we, dd, eclr;
    logic hit;
    wr_en = wr; addr = a; wdata = d; be = b; done = dn; err_ev = ev; err_ch = ch; err_cause = cs;
    lm = {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
    for (int k = 0; k < 8; k++) begin
      cm[k] = '0;
      if (wr && a[1:0] == 2'b00 && a[5:2] == ((k < 4) ? 4'd6 : 4'd7) && b[k % 4])
        cm[k] = sel64(d[8*(k%4) +: 8]);
    end
    ldr = '0; lde = '0; wi = '0; we = '0; dd = {d, d};
    if (wr && a[1:0] == 2'b00) begin
      case (a[5:2])
        4'd0:  m_ctrl = (m_ctrl & ~lm) | (d & lm);
        4'd2:  ldr[63:32] = lm;
        4'd3:  ldr[31:0] = lm;
        4'd4:  lde[63:32] = lm;
        4'd5:  lde[31:0] = lm;
        4'd8:  wi[63:32] = d & lm;
        4'd9:  wi[31:0] = d & lm;
        4'd10: we[63:32] = d & lm;
        4'd11: we[31:0] = d & lm;
        default: ;
      endcase
    end
    m_req = (((m_req & ~ldr) | (dd & ldr)) | cm[0]) & ~cm[1];
    m_eei = (((m_eei & ~lde) | (dd & lde)) | cm[2]) & ~cm[3];
    eclr = we | cm[5];
    hit = m_stat[31] && eclr[m_stat[13:8]];
    if (ev && (!m_stat[31] || hit)) m_stat = {1'b1, 15'd0, cs[9], cs[8], ch, cs[7:0]};
    else if (hit) m_stat = '0;
    m_int = (m_int & ~(wi | cm[4])) | dn;
    m_err = (m_err & ~eclr) | (ev ? (64'd1 << ch) : 64'd0);
    e_start = cm[6];
    e_dclr = cm[7];
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; done = '0; err_ev = 1'b0;
    chk("R11 start pulse", start, e_start);
    chk("R11 done-clear pulse", done_clr, e_dclr);
    chk("R13 req_en_o", req_en, m_req);
    chk("R10 irq", {63'd0, irq}, {63'd0, (|m_int) || (|(m_err & m_eei))});
    read_all();
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] b);
    step(1'b1, a, d, b, '0, 1'b0, '0, '0);
  endtask

  task automatic idle();
    step(1'b0, '0, '0, '0, '0, 1'b0, '0, '0);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_ctrl = '0; m_stat = '0; m_req = '0; m_eei = '0; m_int = '0; m_err = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq after reset", {63'd0, irq}, 64'd0);
    chk("R1 req_en_o after reset", req_en, 64'd0);
    read_all();

    // R2 lane-masked enable word writes
    wr(6'h08, 32'hA5A5_5A5A, 4'b0101);
    addr = 6'h08; #0.1; chk("R2 req hi lanes", {32'd0, rdata}, 64'h0000_0000_00A5_005A);
    wr(6'h14, 32'hFFFF_FFFF, 4'hF);
    chk("R2 eei lo full", m_eei, 64'h0000_0000_FFFF_FFFF);
    wr(6'h08, 32'h0, 4'hF);
    wr(6'h14, 32'h0, 4'hF);

    // R3 single-channel set and clear, bit 7 ignored
    wr(6'h18, 32'h0000_0085, 4'b0001);
    chk("R3 set req ch5 (bit7 ignored)", req_en, 64'h20);
    wr(6'h18, 32'h0000_2300, 4'b0010);
    chk("R3 clr req ch35 leaves ch5", req_en, 64'h20);
    wr(6'h18, 32'h0000_0500, 4'b0010);
    chk("R3 clr req ch5", req_en, 64'h0);
    wr(6'h18, 32'h003F_0000, 4'b0100);
    addr = 6'h10; #0.1; chk("R3 set eei ch63", {32'd0, rdata}, 64'h8000_0000);

    // R4 broadcast
    wr(6'h18, 32'h0000_0040, 4'b0001);
    chk("R4 set all req", req_en, '1);
    wr(6'h18, 32'h4000_0000, 4'b1000);
    chk("R4 clr all eei", m_eei, 64'h0);

    // R5 set and clear same channel in one write
    wr(6'h18, 32'h0000_0707, 4'b0011);
    chk("R5 clear wins ch7", {63'd0, req_en[7]}, 64'd0);
    wr(6'h0C, 32'h0, 4'hF);
    wr(6'h08, 32'h0, 4'hF);

    // R6 done sets interrupt, clears, collision
    step(1'b0, '0, '0, '0, 64'd1 << 40, 1'b0, '0, '0);
    addr = 6'h20; #0.1; chk("R6 int ch40 pending", {32'd0, rdata}, 64'h100);
    chk("R10 irq from int", {63'd0, irq}, 64'd1);
    wr(6'h1C, 32'h0000_0028, 4'b0001);
    addr = 6'h20; #0.1; chk("R6 int cleared by command", {32'd0, rdata}, 64'h0);
    step(1'b1, 6'h24, 32'h0000_0008, 4'hF, 64'd1 << 3, 1'b0, '0, '0);
    addr = 6'h24; #0.1; chk("R6 done beats W1C", {32'd0, rdata}, 64'h8);
    wr(6'h24, 32'h0000_0008, 4'hF);
    chk("R6 W1C clears", m_int, 64'h0);

    // R7 R8 R9 error path
    step(1'b0, '0, '0, '0, '0, 1'b1, 6'd3, 10'h3FF);
    addr = 6'h04; #0.1; chk("R8 estat latched", {32'd0, rdata}, 64'h8000_C3FF);
    chk("R10 err masked by eei", {63'd0, irq}, 64'd0);
    step(1'b0, '0, '0, '0, '0, 1'b1, 6'd9, 10'h001);
    addr = 6'h04; #0.1; chk("R8 second error ignored", {32'd0, rdata}, 64'h8000_C3FF);
    addr = 6'h2C; #0.1; chk("R7 err bits 3 and 9", {32'd0, rdata}, 64'h208);
    wr(6'h18, 32'h0003_0000, 4'b0100);
    chk("R10 irq with err and eei", {63'd0, irq}, 64'd1);
    wr(6'h1C, 32'h0000_0900, 4'b0010);
    addr = 6'h04; #0.1; chk("R9 other channel clear keeps estat", {32'd0, rdata}, 64'h8000_C3FF);
    step(1'b1, 6'h2C, 32'h8, 4'hF, '0, 1'b1, 6'd50, 10'h204);
    addr = 6'h04; #0.1; chk("R9 clear plus new error relatches", {32'd0, rdata}, 64'h8000_B204);
    wr(6'h28, 32'h0004_0000, 4'hF);
    addr = 6'h04; #0.1; chk("R9 clear releases estat", {32'd0, rdata}, 64'h0);

    // R11 pulses
    wr(6'h1C, 32'h0C00_0C00 | 32'h000C_0000, 4'b0100);
    chk("R11 start ch12", start, 64'h1000);
    idle();
    chk("R11 start one cycle", start, 64'h0);
    wr(6'h1C, 32'h4000_0000, 4'b1000);
    chk("R11 done clear all", done_clr, '1);

    // R12 control, hw request, misaligned
    wr(6'h00, 32'hDEAD_BEEF, 4'b1001);
    addr = 6'h00; #0.1; chk("R12 ctrl lanes", {32'd0, rdata}, 64'hDE00_00EF);
    hw_req = 64'h1234_5678_9ABC_DEF0;
    addr = 6'h30; #0.1; chk("R12 hw req hi", {32'd0, rdata}, 64'h1234_5678);
    wr(6'h0D, 32'hFFFF_FFFF, 4'hF);
    addr = 6'h0D; #0.1; chk("R12 misaligned reads 0", {32'd0, rdata}, 64'h0);
    chk("R12 misaligned write ignored", req_en, m_req);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      logic [5:0] a;
      logic [63:0] dn;
      logic ev;
      int op;
      hw_req = {$urandom, $urandom};
      op = $urandom_range(0, 9);
      d = $urandom;
      dn = '0;
      ev = ($urandom_range(0, 5) == 0);
      if ($urandom_range(0, 4) == 0) dn = 64'd1 << $urandom_range(0, 63);
      for (int l = 0; l < 4; l++) d[8*l+6] = ($urandom_range(0, 9) == 0);
      if (op < 4) a = 6'(($urandom_range(0, 15)) << 2);
      else if (op < 8) a = ($urandom_range(0, 1) == 0) ? 6'h18 : 6'h1C;
      else a = 6'h00;
      step(op != 9, a, d, 4'($urandom), dn, ev, 6'($urandom), 10'($urandom));
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule